// File: doc/BRIEF.md
# Pin Bank with Write-Triggered Output Direction

This block is a bank of general-purpose pins behind a small word-addressed register bus. Software does not write a direction register to turn a pin into an output. Writing a one to a pin's bit in the set register or the clear register drives the pin and enables its output driver in the same step. A separate release register hands a pin back to input mode.

Input sampling is blocked after reset. Until software writes the arm register once, the pin-state register reads as zero and every interrupt request line stays low. The value written to the arm register is ignored. After arming, pad levels pass through a two-flop synchronizer. The synchronized levels appear both in the pin-state register and on one level-type interrupt request line per pin. Those lines go to an interrupt controller outside the block.

The register bus uses these word addresses: 0 release, 1 set, 2 clear, 3 arm, 4 pin state, 5 output value, 6 output enable. Reads are combinational from the address. Writes take effect at the clock edge that samples the write strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every output value bit, every output-enable bit and every interrupt request is 0, and the pin-state register (address 4) reads 0.
- R2: A write to the set register (address 1) makes each pin whose data bit is 1 drive high with its output enable asserted from the next clock. Pins whose data bit is 0 keep both their value and their direction.
- R3: A write to the clear register (address 2) makes each pin whose data bit is 1 drive low with its output enable asserted from the next clock. Pins whose data bit is 0 keep both their value and their direction.
- R4: A write to the release register (address 0) deasserts the output enable of each pin whose data bit is 1 on the next clock. Output values are kept, and pins whose data bit is 0 are unchanged.
- R5: Until the arm register has been written, the pin-state register reads 0 and all interrupt requests are 0, whatever the pad levels are.
- R6: Any write to the arm register (address 3) arms input sampling, whatever its data, including all zeros. Input sampling then stays armed until reset.
- R7: Once armed, the pin-state register shows each pad level two clock edges after the pad changes.
- R8: Once armed, each interrupt request equals the synchronized level of its own pin.
- R9: The output-value register (address 5) and the output-enable register (address 6) read back the current output value and output-enable vectors. Writes to read-only addresses change no pin state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (3) | Word address |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Read data for bus_addr |
| pad_in | input | NPINS (32) | Raw pad levels |
| pad_out | output | NPINS (32) | Output values to the pad drivers |
| pad_oe | output | NPINS (32) | Output enables to the pad drivers |
| irq | output | NPINS (32) | Per-pin interrupt request levels |

## Verification
The assertions check several rules on every cycle:
- each set, clear or release write updates exactly its own bits on the next edge;
- pin state does not move without such a write;
- interrupts stay silent while the bank is not armed, and arming never drops;
- once armed, each interrupt line trails its pad by two edges.

Other behaviours need the bench's scenarios:
- a data-agnostic arm, shown with an all-zero write;
- readback through the bus;
- writes to read-only addresses;
- the point in time at which a pad change first becomes visible.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] irq
);
  localparam logic [AW-1:0] A_REL = AW'(0);
  localparam logic [AW-1:0] A_SET = AW'(1);
  localparam logic [AW-1:0] A_CLR = AW'(2);
  localparam logic [AW-1:0] A_ARM = AW'(3);
  localparam logic [AW-1:0] A_PIN = AW'(4);
  localparam logic [AW-1:0] A_OUT = AW'(5);
  localparam logic [AW-1:0] A_OE  = AW'(6);

  logic [NPINS-1:0] out_q, oe_q, sync1, sync2, pins;
  logic             armed;

  wire wr_set = bus_wr && bus_addr == A_SET;
  wire wr_clr = bus_wr && bus_addr == A_CLR;
  wire wr_rel = bus_wr && bus_addr == A_REL;
  wire wr_arm = bus_wr && bus_addr == A_ARM;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else if (wr_set) begin
      out_q <= out_q | bus_wdata;
      oe_q  <= oe_q  | bus_wdata;
    end else if (wr_clr) begin
      out_q <= out_q & ~bus_wdata;
      oe_q  <= oe_q  | bus_wdata;
    end else if (wr_rel) begin
      oe_q  <= oe_q & ~bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else if (wr_arm) armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end

  assign pins    = armed ? sync2 : '0;
  assign irq     = pins;
  assign pad_out = out_q;
  assign pad_oe  = oe_q;

  always_comb
    case (bus_addr)
      A_PIN:   bus_rdata = pins;
      A_OUT:   bus_rdata = out_q;
      A_OE:    bus_rdata = oe_q;
      default: bus_rdata = '0;
    endcase
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] irq,
  input logic             armed
);
  wire w_rel = bus_wr && bus_addr == AW'(0);
  wire w_set = bus_wr && bus_addr == AW'(1);
  wire w_clr = bus_wr && bus_addr == AW'(2);

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)) &&
              ((pad_oe  & $past(bus_wdata)) == $past(bus_wdata)) &&
              ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> ((pad_out & $past(bus_wdata)) == '0) &&
              ((pad_oe  & $past(bus_wdata)) == $past(bus_wdata)) &&
              ((pad_oe  & ~$past(bus_wdata)) == ($past(pad_oe) & ~$past(bus_wdata))));

  p_rel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_rel |=> ((pad_oe & $past(bus_wdata)) == '0) && $stable(pad_out));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_set || w_clr || w_rel) |=> $stable(pad_out) && $stable(pad_oe));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> irq == '0);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed, 2)) |-> irq == $past(pad_in, 2));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq(irq), .armed(armed)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam int N = 32;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, pad_in = '0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    pad_in = 32'hFFFF_FFFF;
    chk("R1 out", pad_out, '0); chk("R1 oe", pad_oe, '0); chk("R1 irq", irq, '0);
    rd(3'd4, d); chk("R1 pin", d, '0);
  endtask

  task automatic t_set;
    wr(3'd1, 32'h0000_00F0);
    chk("R2 out", pad_out, 32'h0000_00F0); chk("R2 oe", pad_oe, 32'h0000_00F0);
    wr(3'd1, 32'h8000_0001);
    chk("R2 out keep", pad_out, 32'h8000_00F1); chk("R2 oe keep", pad_oe, 32'h8000_00F1);
  endtask

  task automatic t_clr;
    wr(3'd2, 32'h0000_0030);
    chk("R3 out", pad_out, 32'h8000_00C1);
    wr(3'd2, 32'h0001_0000);
    chk("R3 oe", pad_oe, 32'h8001_00F1); chk("R3 out low", pad_out, 32'h8000_00C1);
  endtask

  task automatic t_rel;
    wr(3'd0, 32'h8000_0010);
    chk("R4 oe", pad_oe, 32'h0001_00E1); chk("R4 out kept", pad_out, 32'h8000_00C1);
  endtask

  task automatic t_readback;
    logic [N-1:0] d;
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, '0); wr(3'd7, 32'h1234);
    rd(3'd5, d); chk("R9 out rd", d, 32'h8000_00C1);
    rd(3'd6, d); chk("R9 oe rd", d, 32'h0001_00E1);
  endtask

  task automatic t_unarmed;
    logic [N-1:0] d;
    pad_in = 32'hA5A5_5A5A;
    repeat (4) @(negedge clk);
    rd(3'd4, d); chk("R5 pin", d, '0); chk("R5 irq", irq, '0);
  endtask

  task automatic t_arm;
    logic [N-1:0] d;
    wr(3'd3, '0);
    rd(3'd4, d); chk("R6 armed zero data", d, 32'hA5A5_5A5A);
    chk("R8 irq", irq, 32'hA5A5_5A5A);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R6 still armed", d, 32'hA5A5_5A5A);
  endtask

  task automatic t_follow;
    logic [N-1:0] d;
    @(negedge clk); pad_in = 32'h0F0F_1234;
    @(negedge clk); rd(3'd4, d); chk("R7 one edge", d, 32'hA5A5_5A5A);
    @(negedge clk); rd(3'd4, d); chk("R7 two edges", d, 32'h0F0F_1234);
    chk("R8 irq follows", irq, 32'h0F0F_1234);
  endtask

  task automatic t_rereset;
    logic [N-1:0] d;
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    rd(3'd4, d); chk("R6 cleared by reset", d, '0); chk("R1 oe after reset", pad_oe, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_set(); t_clr(); t_rel(); t_readback(); t_unarmed(); t_arm(); t_follow(); t_rereset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); total++; bad++; $display("FAIL watchdog"); end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule